// File: doc/BRIEF.md
# Start Vector Clock Gate

This block sits behind the slicer and bit-clock recovery of a serial radio receiver. Every recovered bit arrives as a one-cycle strobe with its value. The block keeps a history of the last sixteen bits and compares it with a fixed start word. Until that word has been seen, the outgoing data clock stays low. Once it has been seen, the block gives one clock pulse per further received bit and presents that bit on a data pin.

Recognition is armed by a level control. The block synchronises that control to the system clock. A low level clears the recognised state, and a return to high starts a fresh search. A separate enable turns the whole recovery path off, which holds the data clock low.

The bit input is a valid-only stream with no ready signal. No back-pressure exists: every strobe is taken in the cycle it appears. Strobes must be at least PULSE_CYC+1 system clocks apart so that each output pulse can finish before the next one starts.

Top module: `svg_gate`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dclk_out` and `dat_out` are 0 and no start word is recognised.
- R2: Each accepted strobe shifts `bit_in` into a 16-bit history, with the earliest bit at the most significant end. Recognition happens on the strobe whose bit completes the history value 0xE2E2.
- R3: `dclk_out` stays 0 until the start word is recognised. The sixteen bits of the start word produce no pulse.
- R4: After recognition, every strobe produces exactly one pulse on `dclk_out`. The first pulse belongs to the first bit after the start word. Recognition persists across any data that follows, including further copies of the start word.
- R5: `dat_out` takes the strobed bit on the same clock edge where `dclk_out` rises. It holds that value through the pulse's falling edge and until the next pulse rises.
- R6: Each pulse stays high for exactly PULSE_CYC system clock cycles. The default is 3.
- R7: `arm_in` passes through a two-stage synchroniser. A synchronised low level clears the recognition and the history and forces `dclk_out` low. The next recognition needs a complete start word received after `arm_in` is high again. Bits received before the low level do not count toward it.
- R8: While `rec_en` is 0, `dclk_out` is held at 0, strobes are ignored, and the recognition and history are cleared. A complete new start word is needed after re-enable.
- R9: A word that differs from 0xE2E2 in any bit does not trigger recognition. The start word is found at any bit offset within an ongoing stream.
- R10: Strobes spaced PULSE_CYC+1 cycles apart are all accepted, with no back-pressure and no lost pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rec_en | input | 1 | Enables the recovery path; 0 holds the clock output low |
| arm_in | input | 1 | Asynchronous arm level; low clears recognition, high searches |
| bit_valid | input | 1 | One-cycle strobe marking a recovered bit |
| bit_in | input | 1 | Sliced data bit, sampled when `bit_valid` is 1 |
| dclk_out | output | 1 | Gated data clock, one pulse per bit after the start word |
| dat_out | output | 1 | Data bit that goes with the current output clock pulse |

## Verification
A wrong recognition flag shows up at the ports on the very next strobe. A flag stuck high gives a pulse for a start-word bit. A flag that is lost or never set gives a missing pulse. A damaged history register shifts the first pulse by one or more bit periods, or suppresses it entirely. A mistake in the pulse timer or the data register appears within PULSE_CYC cycles as a wrong width or a data change while the clock is high. Comparing both outputs against a model on every cycle therefore catches such faults within one bit period.

// File: rtl/svg_pkg.sv
package svg_pkg;
  localparam int unsigned SVG_PAT_W       = 16;
  localparam logic [15:0] SVG_PATTERN     = 16'hE2E2;
  localparam int unsigned SVG_PULSE_CYC   = 3;
  localparam int unsigned SVG_SYNC_STAGES = 2;
endpackage

// File: rtl/svg_arm_sync.sv
module svg_arm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_in,
  output logic arm_s
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= arm_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], arm_in};
      end
    end
  endgenerate

  assign arm_s = chain[STAGES-1];
endmodule

// File: rtl/svg_detect.sv
module svg_detect #(
  parameter int unsigned         PAT_W   = 16,
  parameter logic [PAT_W-1:0]    PATTERN = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bit_valid,
  input  logic bit_in,
  output logic locked
);
  logic [PAT_W-1:0] hist;
  logic [PAT_W-1:0] next_hist;

  assign next_hist = {hist[PAT_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= '0;
      locked <= 1'b0;
    end else if (!enable) begin
      hist   <= '0;
      locked <= 1'b0;
    end else if (bit_valid && !locked) begin
      hist <= next_hist;
      if (next_hist == PATTERN) locked <= 1'b1;
    end
  end

  // R2: recognition only ever begins on a bit strobe
  a_r2_lock_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(bit_valid));

  // R8: a disabled path never keeps the recognition
  a_r8_unlock_when_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !locked);
endmodule

// File: rtl/svg_pulse.sv
module svg_pulse #(
  parameter int unsigned PULSE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic locked,
  input  logic bit_valid,
  input  logic bit_in,
  output logic clk_out,
  output logic data_out
);
  localparam int unsigned CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             start;

  assign start = enable && locked && bit_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out  <= 1'b0;
      cnt      <= '0;
      data_out <= 1'b0;
    end else if (!enable) begin
      clk_out <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      clk_out  <= 1'b1;
      cnt      <= CNT_LOAD;
      data_out <= bit_in;
    end else if (clk_out) begin
      if (cnt == '0) clk_out <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  // checker: length of the current high run
  int unsigned hi_run;
  always_ff @(posedge clk) begin
    if (rst)          hi_run <= 0;
    else if (clk_out) hi_run <= hi_run + 1;
    else              hi_run <= 0;
  end

  // R6: no pulse exceeds the programmed width
  a_r6_width_limit: assert property (@(posedge clk) disable iff (rst)
    clk_out |-> hi_run < PULSE_CYC);

  // R5: data only moves together with a high clock
  a_r5_data_with_clock: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_out) |-> clk_out);
endmodule

// File: rtl/svg_gate.sv
module svg_gate
  import svg_pkg::*;
#(
  parameter int unsigned      PAT_W       = SVG_PAT_W,
  parameter logic [PAT_W-1:0] PATTERN     = PAT_W'(SVG_PATTERN),
  parameter int unsigned      PULSE_CYC   = SVG_PULSE_CYC,
  parameter int unsigned      SYNC_STAGES = SVG_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic rec_en,
  input  logic arm_in,
  input  logic bit_valid,
  input  logic bit_in,
  output logic dclk_out,
  output logic dat_out
);
  logic arm_s;
  logic path_on;
  logic locked;

  svg_arm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .arm_in (arm_in),
    .arm_s  (arm_s)
  );

  assign path_on = rec_en && arm_s;

  svg_detect #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .enable    (path_on),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .locked    (locked)
  );

  svg_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk       (clk),
    .rst       (rst),
    .enable    (path_on),
    .locked    (locked),
    .bit_valid (bit_valid),
    .bit_in    (bit_in),
    .clk_out   (dclk_out),
    .data_out  (dat_out)
  );

  // R3: a pulse starts only after recognition was already in place
  a_r3_rise_needs_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(dclk_out) |-> $past(locked));

  // R8: a disabled path drives no clock
  a_r8_off_clock_low: assert property (@(posedge clk) disable iff (rst)
    !rec_en |=> !dclk_out);

  // R7: a synchronised disarm drops the clock
  a_r7_disarm_clock_low: assert property (@(posedge clk) disable iff (rst)
    !arm_s |=> !dclk_out);
endmodule

// File: tb/tb_svg_gate.sv
module tb_svg_gate;
  localparam int PULSE = 3;
  localparam int GAP   = PULSE + 1;
  localparam int HALF  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rec_en = 1'b0, arm_in = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic dclk_out, dat_out;

  svg_gate dut (
    .clk(clk), .rst(rst), .rec_en(rec_en), .arm_in(arm_in),
    .bit_valid(bit_valid), .bit_in(bit_in),
    .dclk_out(dclk_out), .dat_out(dat_out)
  );

  always #(HALF) clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  int pulses = 0, run = 0, last_width = 0;
  bit prev_clk = 0;
  bit rises[$];
  string cur_req = "R1";

  // behavioural model
  int m_a1 = 0, m_a2 = 0, m_hist = 0, m_lock = 0, m_hi = 0, m_dat = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_a1 = 0; m_a2 = 0; m_hist = 0; m_lock = 0; m_hi = 0; m_dat = 0;
    end else begin
      if (!(rec_en && m_a2 != 0)) begin
        m_hist = 0; m_lock = 0; m_hi = 0;
      end else if (bit_valid && m_lock != 0) begin
        m_dat = int'(bit_in); m_hi = PULSE;
      end else begin
        if (bit_valid) begin
          m_hist = ((m_hist << 1) | int'(bit_in)) & 16'hFFFF;
          if (m_hist == 16'hE2E2) m_lock = 1;
        end
        if (m_hi > 0) m_hi = m_hi - 1;
      end
      m_a2 = m_a1; m_a1 = int'(arm_in);
    end
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    chk({cur_req, " dclk_out"}, int'(dclk_out), (m_hi > 0) ? 1 : 0);
    chk({cur_req, " dat_out"}, int'(dat_out), m_dat);
    if (dclk_out && !prev_clk) begin
      pulses++; rises.push_back(dat_out); run = 1;
    end else if (dclk_out) run++;
    else if (prev_clk) last_width = run;
    prev_clk = dclk_out;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic strobe(bit b);
    @(negedge clk); bit_in = b; bit_valid = 1'b1;
    @(negedge clk); bit_valid = 1'b0;
    repeat (GAP - 1) @(negedge clk);
  endtask

  task automatic send(logic [15:0] w, int n);
    for (int i = n - 1; i >= 0; i--) strobe(w[i]);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1 reset state
    idle(3);
    chk("R1 reset clk", int'(dclk_out), 0);
    chk("R1 reset dat", int'(dat_out), 0);
    @(negedge clk); rst = 1'b0; rec_en = 1'b1; arm_in = 1'b1;
    chk("R1 post-reset clk", int'(dclk_out), 0);
    idle(4);

    // R9 near miss and R3 gating
    cur_req = "R9"; pulses = 0;
    send(16'h0000, 16); send(16'hE2E3, 16); send(16'h0000, 16);
    send(16'h6262, 16);
    chk("R9 near miss no pulses", pulses, 0);

    // R2 / R3 pattern at odd offset, no pulses for its bits
    cur_req = "R3"; pulses = 0;
    send(16'h0005, 3); send(16'hE2E2, 16);
    chk("R3 pattern bits give no pulse", pulses, 0);

    // R4 / R5 / R10 data after the start word
    cur_req = "R4"; pulses = 0; rises.delete();
    send(16'h00A5, 8);
    idle(PULSE + 2);
    chk("R4 one pulse per bit", pulses, 8);
    chk("R6 pulse width", last_width, PULSE);
    for (int i = 0; i < 8; i++)
      if (i < rises.size()) chk("R5 data at rise", int'(rises[i]), int'(8'hA5 >> (7 - i)) & 1);
    chk("R10 all strobes accepted", rises.size(), 8);

    // R4 start word repeated as data keeps clocking
    pulses = 0;
    send(16'hE2E2, 16);
    chk("R4 stays locked", pulses, 16);

    // R8 disable
    cur_req = "R8"; pulses = 0;
    @(negedge clk); rec_en = 1'b0;
    send(16'h00FF, 8);
    chk("R8 no clock while off", pulses, 0);
    @(negedge clk); rec_en = 1'b1;
    send(16'h000F, 4);
    chk("R8 lock cleared", pulses, 0);
    send(16'hE2E2, 16); send(16'h0009, 4);
    chk("R8 relock after word", pulses, 4);

    // R7 disarm, split word across disarm
    cur_req = "R7"; pulses = 0;
    @(negedge clk); arm_in = 1'b0;
    idle(4);
    send(16'h0003, 2);
    chk("R7 no clock while disarmed", pulses, 0);
    @(negedge clk); arm_in = 1'b1; idle(3);
    send(16'h00E2, 8);
    @(negedge clk); arm_in = 1'b0; idle(4);
    @(negedge clk); arm_in = 1'b1; idle(3);
    send(16'h00E2, 8); send(16'h0007, 3);
    chk("R7 history cleared by disarm", pulses, 0);
    send(16'hE2E2, 16); send(16'h0005, 3);
    chk("R7 rearmed lock", pulses, 3);

    // R7 disarm in the middle of a pulse
    @(negedge clk); bit_in = 1'b1; bit_valid = 1'b1;
    @(negedge clk); bit_valid = 1'b0; arm_in = 1'b0;
    idle(6);
    chk("R7 clock low after disarm", int'(dclk_out), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule